// File: doc/BRIEF.md
# Inter-processor doorbell register block

This peripheral sits on an APB slave port and lets software on either processor post events to a target CPU and withdraw them. Each target CPU owns a small event status register. Software never writes the status register directly. It posts events through a write-one-to-set register and withdraws them through a separate write-one-to-clear register, so that each event bit can be handled independently without a read-modify-write sequence. A level interrupt line per CPU stays high while any of that CPU's event bits is set.

The top of the 4 KB register window holds constant identification words. A build-time parameter selects a single-core build. In that build the second CPU's registers read as zero, ignore writes, and its interrupt line never rises. The block returns read data with no wait states and never signals an error.

Top module: `doorbell_unit`

## Requirements
- R1: After a synchronous active-high reset, every event status bit is 0 and both interrupt lines are low.
- R2: A full-word write with bit n set to 1, sent to the set register (CPU0 at offset 0x004, CPU1 at 0x014), sets status bit n of that CPU. Bits written as 0 leave their status bits unchanged.
- R3: A full-word write with bit n set to 1, sent to the clear register (CPU0 at 0x008, CPU1 at 0x018), clears status bit n of that CPU. Bits written as 0 leave their status bits unchanged.
- R4: A CPU's interrupt line is high exactly when any of its 4 status bits is 1. It reflects a write starting in the cycle after that write's access phase.
- R5: A read of offset 0x000 (CPU0) or 0x010 (CPU1) returns the 4 event bits in [3:0] and zeros in [31:4].
- R6: A write whose byte strobes are not all ones (PSTRB other than 4'b1111) changes no state.
- R7: In the single-core build, reads of the CPU1 registers return 0, writes to them have no effect, and the CPU1 interrupt line stays low.
- R8: The identification offsets read fixed values: 0xFD0 returns 0x04; 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x56, 0xB8, 0x0B and 0x00; 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x0D, 0xF0, 0x05 and 0xB1.
- R9: Reads of the set and clear registers and of reserved offsets return 0. Writes to the status registers, the identification registers or reserved offsets change no state.
- R10: PREADY is high and PSLVERR is low in every access phase.
- R11: Read data is valid throughout the access phase of the transfer that requests it, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq | output | 2 | Level interrupt per CPU, bit c for CPU c |

## Verification
When transfers run back to back, the edge that commits a set or clear write is the same edge that opens the setup phase of the next transfer. That setup edge is also where read data is captured. The bench issues set and clear writes immediately followed by a status read, with no idle cycle between them, and requires the read to return the value after the write. Both interrupt lines are compared against a behavioural model on every clock. A single-core instance on the same bus is judged against its own model in parallel.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned STRB_W = REG_W / 8;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_STAT,
    KIND_SET,
    KIND_CLR,
    KIND_ID
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      cpu;
  } reg_sel_t;

  // Constant identification words at the top of the 4 KB window.
  function automatic logic [7:0] id_byte(input logic [11:0] off);
    case (off)
      12'hFD0: id_byte = 8'h04;
      12'hFE0: id_byte = 8'h56;
      12'hFE4: id_byte = 8'hB8;
      12'hFE8: id_byte = 8'h0B;
      12'hFEC: id_byte = 8'h00;
      12'hFF0: id_byte = 8'h0D;
      12'hFF4: id_byte = 8'hF0;
      12'hFF8: id_byte = 8'h05;
      12'hFFC: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter bit          DUAL_CORE = 1'b1
) (
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_t          sel
);
  localparam int unsigned WIN_W = 12;

  logic [WIN_W-1:0] off;
  assign off = paddr[WIN_W-1:0];

  always_comb begin
    sel.kind = KIND_NONE;
    sel.cpu  = off[4];
    if (off[1:0] == 2'b00) begin
      if (off[WIN_W-1:5] == '0) begin
        case (off[3:2])
          2'd0:    sel.kind = KIND_STAT;
          2'd1:    sel.kind = KIND_SET;
          2'd2:    sel.kind = KIND_CLR;
          default: sel.kind = KIND_NONE;
        endcase
        if (off[4] && !DUAL_CORE) sel.kind = KIND_NONE;
      end else if (off >= 12'hFD0) begin
        sel.kind = KIND_ID;
      end
    end
  end
endmodule

// File: rtl/doorbell_event_bank.sv
module doorbell_event_bank #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_EVT-1:0] wmask,
  output logic [NUM_EVT-1:0] status,
  output logic               irq
);
  logic [NUM_EVT-1:0] status_n;

  always_comb begin
    status_n = status;
    if (set_we) status_n = status_n | wmask;
    if (clr_we) status_n = status_n & ~wmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      irq    <= |status_n;
    end
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((status & $past(wmask)) == $past(wmask)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status & $past(wmask)) == '0));

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_EVT   = 4,
  parameter bit          DUAL_CORE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]  pwdata,
  input  logic [STRB_W-1:0] pstrb,
  output logic [REG_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [1:0]        irq
);
  localparam int unsigned NUM_CPU = 2;

  reg_sel_t                        sel;
  logic                            wr_ok;
  logic [NUM_CPU-1:0][NUM_EVT-1:0] stat_all;

  doorbell_decode #(.ADDR_W(ADDR_W), .DUAL_CORE(DUAL_CORE)) u_decode (
    .paddr (paddr),
    .sel   (sel)
  );

  assign wr_ok = psel && penable && pwrite && (&pstrb);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    if (c == 0 || DUAL_CORE) begin : g_bank
      logic set_we, clr_we;
      assign set_we = wr_ok && (sel.kind == KIND_SET) && (sel.cpu == 1'(c));
      assign clr_we = wr_ok && (sel.kind == KIND_CLR) && (sel.cpu == 1'(c));
      doorbell_event_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_we (set_we),
        .clr_we (clr_we),
        .wmask  (pwdata[NUM_EVT-1:0]),
        .status (stat_all[c]),
        .irq    (irq[c])
      );
    end else begin : g_absent
      assign stat_all[c] = '0;
      assign irq[c]      = 1'b0;
    end
  end

  // Read data is captured in the setup phase so it is valid for the whole access phase.
  logic [REG_W-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    case (sel.kind)
      KIND_STAT: rd_n[NUM_EVT-1:0] = stat_all[sel.cpu];
      KIND_ID:   rd_n[7:0]         = id_byte(paddr[11:0]);
      default:   rd_n              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                prdata <= '0;
    else if (psel && !penable && !pwrite)   prdata <= rd_n;
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assert_subword_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && !(&pstrb)) |=> $stable(stat_all));

  assert_rsvd_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable && !pwrite && sel.kind == KIND_NONE) |=> (prdata == '0));

  assert_inert_write_R9: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && (sel.kind == KIND_STAT || sel.kind == KIND_ID
      || sel.kind == KIND_NONE)) |=> $stable(stat_all));
endmodule

// File: tb/tb_doorbell_unit.sv
module tb_doorbell_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = 4'hF;
  logic [31:0] prdata, prdata_sc;
  logic        pready, pslverr, pready_sc, pslverr_sc;
  logic [1:0]  irq, irq_sc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model: dual-core status per CPU, single-core CPU0 status
  int unsigned m0 = 0, m1 = 0, s0 = 0;

  always #10 clk = ~clk;

  doorbell_unit dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq(irq));

  doorbell_unit #(.DUAL_CORE(1'b0)) dut_sc (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata_sc),
    .pready(pready_sc), .pslverr(pslverr_sc), .irq(irq_sc));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m0 = 0; m1 = 0; s0 = 0;
    end else if (psel && penable && pwrite && pstrb == 4'hF) begin
      case (paddr)
        12'h004: begin m0 = m0 | pwdata[3:0]; s0 = s0 | pwdata[3:0]; end
        12'h008: begin m0 = m0 & ~pwdata[3:0] & 4'hF; s0 = s0 & ~pwdata[3:0] & 4'hF; end
        12'h014: m1 = m1 | pwdata[3:0];
        12'h018: m1 = m1 & ~pwdata[3:0] & 4'hF;
        default: ;
      endcase
    end
  end

  // R4 / R7: interrupt lines against the model every clock
  always @(negedge clk) begin
    if (!done) begin
      check("R4 irq dual", {30'd0, irq}, {30'd0, (m1 != 0), (m0 != 0)});
      check("R7 irq single", {30'd0, irq_sc}, {30'd0, 1'b0, (s0 != 0)});
    end
  end

  function automatic logic [31:0] exp_read(input logic [11:0] a, input bit dual);
    case (a)
      12'h000: exp_read = dual ? m0 : s0;
      12'h010: exp_read = dual ? m1 : 0;
      12'hFD0: exp_read = 32'h04;
      12'hFE0: exp_read = 32'h56;
      12'hFE4: exp_read = 32'hB8;
      12'hFE8: exp_read = 32'h0B;
      12'hFEC: exp_read = 32'h00;
      12'hFF0: exp_read = 32'h0D;
      12'hFF4: exp_read = 32'hF0;
      12'hFF8: exp_read = 32'h05;
      12'hFFC: exp_read = 32'hB1;
      default: exp_read = 32'h0;
    endcase
  endfunction

  // Called just after a falling edge; leaves the bus ready for an immediate next transfer.
  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] s, input string req);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1'b1;
    check("R10 pready", {31'd0, pready}, 32'd1);
    check("R10 pslverr", {31'd0, pslverr | pslverr_sc}, 32'd0);
    if (!wr) begin
      check({req, " R11 read dual"}, prdata, exp_read(a, 1'b1));
      check({req, " R11 read single"}, prdata_sc, exp_read(a, 1'b0));
    end
    @(negedge clk);
  endtask

  task automatic idle();
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", {30'd0, irq}, 32'd0);
    xfer(0, 12'h000, 0, 4'hF, "R1 R5");
    xfer(0, 12'h010, 0, 4'hF, "R1 R5");
    // R8 identification words, R9 reserved offsets
    for (int i = 0; i < 13; i++) xfer(0, 12'hFD0 + 12'(i * 4), 0, 4'hF, "R8");
    xfer(0, 12'h00C, 0, 4'hF, "R9");
    xfer(0, 12'h800, 0, 4'hF, "R9");
    // R2 set and back-to-back readback
    xfer(1, 12'h004, 32'hFFFF_FFF5, 4'hF, "R2");
    xfer(0, 12'h000, 0, 4'hF, "R2 R5");
    xfer(1, 12'h014, 32'h0000_000A, 4'hF, "R2");
    xfer(0, 12'h010, 0, 4'hF, "R2 R7");
    xfer(1, 12'h004, 32'h0000_0002, 4'hF, "R2");
    xfer(0, 12'h000, 0, 4'hF, "R2");
    // R3 clear, zeros leave bits alone
    xfer(1, 12'h008, 32'h0000_0001, 4'hF, "R3");
    xfer(0, 12'h000, 0, 4'hF, "R3");
    xfer(1, 12'h018, 32'h0000_0002, 4'hF, "R3");
    xfer(0, 12'h010, 0, 4'hF, "R3");
    // R9 set/clear read zero; writes to status, id and reserved ignored
    xfer(0, 12'h004, 0, 4'hF, "R9");
    xfer(0, 12'h018, 0, 4'hF, "R9");
    xfer(1, 12'h000, 32'hF, 4'hF, "R9");
    xfer(1, 12'hFE0, 32'hF, 4'hF, "R9");
    xfer(1, 12'h01C, 32'hF, 4'hF, "R9");
    xfer(0, 12'h000, 0, 4'hF, "R9");
    xfer(0, 12'hFE0, 0, 4'hF, "R9");
    // R6 sub-word writes ignored
    xfer(1, 12'h004, 32'hF, 4'h3, "R6");
    xfer(1, 12'h018, 32'hF, 4'h1, "R6");
    xfer(1, 12'h008, 32'hF, 4'hE, "R6");
    xfer(0, 12'h000, 0, 4'hF, "R6");
    xfer(0, 12'h010, 0, 4'hF, "R6");
    // R4 drain all bits, irq must fall
    xfer(1, 12'h008, 32'hF, 4'hF, "R4");
    xfer(1, 12'h018, 32'hF, 4'hF, "R4");
    xfer(0, 12'h000, 0, 4'hF, "R4");
    idle();
    idle();
    // R7 single-core writes to CPU1 have no effect
    xfer(1, 12'h014, 32'hF, 4'hF, "R7");
    xfer(0, 12'h010, 0, 4'hF, "R7");
    idle();
    // R1 reset mid-run clears everything
    xfer(1, 12'h004, 32'h9, 4'hF, "R1");
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {30'd0, irq}, 32'd0);
    xfer(0, 12'h000, 0, 4'hF, "R1");
    xfer(0, 12'h010, 0, 4'hF, "R1");
    idle();
    finish_report();
  end
endmodule